// File: doc/BRIEF.md
# Host Byte Port

This block gives an external processor access to an 8-bit byte mailbox over a parallel bus. The bus uses three active-low control inputs: chip select, read strobe and write strobe. When the host is selected and pulls the write strobe low, the block takes the byte on the bus into an input holding register. When the host is selected and pulls the read strobe low, the block drives the byte that local firmware left in an output holding register. The host pins do not share a clock with the block, so they are synchronized before the block acts on them.

Local firmware reaches the block through a simple register bus with two addresses. One address is the data register: a read returns the last byte the host wrote, and a write loads the byte the host will read next. The other address is the control register. It holds the mode enable, four pin direction bits and three handshake flags. The flags show whether the host has written a byte that firmware has not yet taken, whether firmware has loaded a byte the host has not yet read, and whether a host write overran a byte that had not been read.

While the mode enable is clear, the block ignores all host strobes and never drives the bus.

Top module: `host_byte_port`

## Requirements
- R1: After reset the control register reads 0x0F and the bus output enable is low. In the control register, bit 7 is input-full, bit 6 is output-full, bit 5 is overrun, bit 4 is mode enable and bits 3:0 are direction bits.
- R2: A host write is a period with chip select and write strobe both low while mode is set. When the first of the two returns high, the byte is stored and input-full (bit 7) is set. A local read of address 0 then returns that byte. Local read data appears on the cycle after the read request.
- R3: A host write that completes while input-full is already set sets overrun (bit 5), and the new byte replaces the old one.
- R4: A local read of address 0 clears input-full.
- R5: A local write to address 0 loads the output byte and sets output-full (bit 6). While the host is selected with the read strobe low, the block asserts the bus output enable and drives that byte. The end of the host read clears output-full.
- R6: The bus output enable goes low no later than the first clock edge after chip select or the read strobe returns high.
- R7: With mode enable clear, host strobes have no effect. No byte is stored, the flags do not change and the bus output enable stays low.
- R8: Overrun is cleared only by a local write of 0 to control bit 5. Writing 1 to bits 7, 6 or 5 of the control register changes nothing.
- R9: Read or write strobes while chip select is high are ignored.
- R10: Control bits 4:0 can be written and read back at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_bus_in | input | DATA_W | Byte bus value as seen at the pins |
| host_bus_out | output | DATA_W | Byte driven toward the host |
| host_bus_oe | output | 1 | Output enable for the byte bus |
| loc_addr | input | ADDR_W | Local register address: 0 = data, 1 = control |
| loc_wr | input | 1 | Local write request |
| loc_rd | input | 1 | Local read request |
| loc_wdata | input | DATA_W | Local write data |
| loc_rdata | output | DATA_W | Local read data, valid on the cycle after loc_rd |

## Verification
Wrong flag state shows up on the next local read of the control register. For example, a missed input-full set or a lost overrun reads back wrong as soon as firmware polls, and an output-full flag stuck high stays visible after the host read ends. Wrong byte storage is visible at the data address, or on the host bus during the next host read, within a few cycles after the strobe synchronizer settles. A faulty output-enable path shows up immediately at host_bus_oe, one edge after chip select or read strobe rises.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int unsigned ADDR_DATA = 0;
  localparam int unsigned ADDR_CTRL = 1;
  localparam int unsigned CB_IBF  = 7;
  localparam int unsigned CB_OBF  = 6;
  localparam int unsigned CB_OVF  = 5;
  localparam int unsigned CB_MODE = 4;
  localparam int unsigned DIR_W   = CB_MODE;
  localparam int unsigned CTL_SEL = 0;
  localparam int unsigned CTL_RD  = 1;
  localparam int unsigned CTL_WR  = 2;
  localparam int unsigned CTL_W   = 3;
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_V  = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {W{RST_V}};
    end else begin
      stg[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/hbp_host_ctl.sv
module hbp_host_ctl
  import hbp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_en,
  input  logic [CTL_W-1:0]  ctl_s,
  input  logic [DATA_W-1:0] bus_s,
  input  logic              sel_n_raw,
  input  logic              rd_n_raw,
  output logic              wr_commit,
  output logic [DATA_W-1:0] wr_byte,
  output logic              rd_done,
  output logic              bus_oe
);
  logic wr_act, rd_act, wr_act_d, rd_act_d, oe_q;
  logic [1:0] fast_q;

  assign wr_act = mode_en & ~ctl_s[CTL_SEL] & ~ctl_s[CTL_WR];
  assign rd_act = mode_en & ~ctl_s[CTL_SEL] & ~ctl_s[CTL_RD];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act_d <= 1'b0;
      rd_act_d <= 1'b0;
      oe_q     <= 1'b0;
      fast_q   <= 2'b11;
      wr_byte  <= '0;
    end else begin
      wr_act_d <= wr_act;
      rd_act_d <= rd_act;
      oe_q     <= rd_act;
      fast_q   <= {rd_n_raw, sel_n_raw};
      if (wr_act) wr_byte <= bus_s;
    end
  end

  assign wr_commit = mode_en & wr_act_d & ~wr_act;
  assign rd_done   = mode_en & rd_act_d & ~rd_act;
  // single-flop path lets the enable drop one edge after a strobe rises
  assign bus_oe    = oe_q & mode_en & ~fast_q[0] & ~fast_q[1];
endmodule

// File: rtl/hbp_regs.sv
module hbp_regs
  import hbp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              loc_wr,
  input  logic              loc_rd,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] loc_rdata,
  input  logic              wr_commit,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_done,
  output logic [DATA_W-1:0] out_byte,
  output logic              mode_en,
  output logic              ibf,
  output logic              obf,
  output logic              ovf
);
  logic [DATA_W-1:0] in_byte;
  logic [DIR_W-1:0]  dir_q;
  logic [DATA_W-1:0] ctrl_view;
  logic sel_data, sel_ctrl;

  assign sel_data = (loc_addr == ADDR_W'(ADDR_DATA));
  assign sel_ctrl = (loc_addr == ADDR_W'(ADDR_CTRL));

  always_comb begin
    ctrl_view          = '0;
    ctrl_view[DIR_W-1:0] = dir_q;
    ctrl_view[CB_MODE] = mode_en;
    ctrl_view[CB_OVF]  = ovf;
    ctrl_view[CB_OBF]  = obf;
    ctrl_view[CB_IBF]  = ibf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_byte   <= '0;
      out_byte  <= '0;
      dir_q     <= '1;
      mode_en   <= 1'b0;
      ibf       <= 1'b0;
      obf       <= 1'b0;
      ovf       <= 1'b0;
      loc_rdata <= '0;
    end else begin
      if (loc_wr && sel_ctrl) begin
        mode_en <= loc_wdata[CB_MODE];
        dir_q   <= loc_wdata[DIR_W-1:0];
        if (!loc_wdata[CB_OVF]) ovf <= 1'b0;
      end
      if (wr_commit && ibf) ovf <= 1'b1;

      if (loc_wr && sel_data) out_byte <= loc_wdata;

      if (loc_wr && sel_data) obf <= 1'b1;
      else if (rd_done)       obf <= 1'b0;

      if (wr_commit) begin
        in_byte <= wr_byte;
        ibf     <= 1'b1;
      end else if (loc_rd && sel_data) begin
        ibf <= 1'b0;
      end

      if (loc_rd) begin
        if (sel_data)      loc_rdata <= in_byte;
        else if (sel_ctrl) loc_rdata <= ctrl_view;
        else               loc_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/host_byte_port.sv
module host_byte_port
  import hbp_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [DATA_W-1:0] host_bus_in,
  output logic [DATA_W-1:0] host_bus_out,
  output logic              host_bus_oe,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              loc_wr,
  input  logic              loc_rd,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] loc_rdata
);
  logic [CTL_W-1:0]  ctl_raw, ctl_s;
  logic [DATA_W-1:0] bus_s, wr_byte;
  logic wr_commit, rd_done, mode_en, ibf, obf, ovf;

  always_comb begin
    ctl_raw          = '1;
    ctl_raw[CTL_SEL] = host_sel_n;
    ctl_raw[CTL_RD]  = host_rd_n;
    ctl_raw[CTL_WR]  = host_wr_n;
  end

  hbp_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_V(1'b1)) ctl_sync_i (
    .clk(clk), .rst(rst), .d_async(ctl_raw), .q_sync(ctl_s)
  );

  hbp_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_V(1'b0)) bus_sync_i (
    .clk(clk), .rst(rst), .d_async(host_bus_in), .q_sync(bus_s)
  );

  hbp_host_ctl #(.DATA_W(DATA_W)) host_ctl_i (
    .clk(clk), .rst(rst), .mode_en(mode_en), .ctl_s(ctl_s), .bus_s(bus_s),
    .sel_n_raw(host_sel_n), .rd_n_raw(host_rd_n),
    .wr_commit(wr_commit), .wr_byte(wr_byte), .rd_done(rd_done),
    .bus_oe(host_bus_oe)
  );

  hbp_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .loc_addr(loc_addr), .loc_wr(loc_wr),
    .loc_rd(loc_rd), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .wr_commit(wr_commit), .wr_byte(wr_byte), .rd_done(rd_done),
    .out_byte(host_bus_out), .mode_en(mode_en),
    .ibf(ibf), .obf(obf), .ovf(ovf)
  );
endmodule

// File: rtl/hbp_checker.sv
module hbp_checker
  import hbp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              host_sel_n,
  input logic              host_rd_n,
  input logic              host_bus_oe,
  input logic [ADDR_W-1:0] loc_addr,
  input logic              loc_wr,
  input logic              loc_rd,
  input logic [DATA_W-1:0] loc_wdata,
  input logic              mode_en,
  input logic              wr_commit,
  input logic              ibf,
  input logic              obf,
  input logic              ovf
);
  p_oe_sel_r6: assert property (@(posedge clk) disable iff (rst)
    (host_sel_n && $past(host_sel_n)) |-> !host_bus_oe);
  p_oe_rd_r6: assert property (@(posedge clk) disable iff (rst)
    (host_rd_n && $past(host_rd_n)) |-> !host_bus_oe);
  p_oe_mode_r7: assert property (@(posedge clk) disable iff (rst)
    (!mode_en && $past(!mode_en)) |-> !host_bus_oe);
  p_ibf_set_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ibf) |-> $past(wr_commit));
  p_ibf_clear_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ibf) |-> $past(loc_rd && loc_addr == ADDR_W'(ADDR_DATA)));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(wr_commit && ibf));
  p_ovf_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf) |-> $past(loc_wr && loc_addr == ADDR_W'(ADDR_CTRL) && !loc_wdata[CB_OVF]));
  p_obf_set_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(obf) |-> $past(loc_wr && loc_addr == ADDR_W'(ADDR_DATA)));
endmodule

bind host_byte_port hbp_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .host_sel_n(host_sel_n), .host_rd_n(host_rd_n),
  .host_bus_oe(host_bus_oe), .loc_addr(loc_addr), .loc_wr(loc_wr),
  .loc_rd(loc_rd), .loc_wdata(loc_wdata), .mode_en(mode_en),
  .wr_commit(wr_commit), .ibf(ibf), .obf(obf), .ovf(ovf)
);

// File: tb/host_byte_port_tb_top.sv
`timescale 1ns/1ps
module host_byte_port_tb_top;
  localparam int DW = 8;
  localparam int AW = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out;
  logic bus_oe;
  logic [AW-1:0] addr = '0;
  logic lwr = 1'b0, lrd = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [DW-1:0] exp; string tag; } item_t;
  item_t sb_q[$];
  logic rd_seen = 1'b0;

  always #4 clk = ~clk;

  host_byte_port #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .host_sel_n(sel_n), .host_rd_n(rd_n),
    .host_wr_n(wr_n), .host_bus_in(bus_in), .host_bus_out(bus_out),
    .host_bus_oe(bus_oe), .loc_addr(addr), .loc_wr(lwr), .loc_rd(lrd),
    .loc_wdata(wdata), .loc_rdata(rdata)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // monitor: compare read data the cycle after each local read
  always @(posedge clk) rd_seen <= lrd;
  always @(negedge clk) begin
    if (rd_seen) begin
      item_t it;
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard empty actual=0x%02h expected=none", rdata);
      end else begin
        it = sb_q.pop_front();
        chk(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic loc_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; lwr = 1'b1;
    @(negedge clk); lwr = 1'b0;
  endtask

  task automatic loc_read(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); addr = a; lrd = 1'b1;
    @(negedge clk); lrd = 1'b0;
    @(negedge clk);
  endtask

  task automatic host_write(logic [DW-1:0] d, bit use_sel);
    @(negedge clk); bus_in = d; wr_n = 1'b0; sel_n = !use_sel;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk); sel_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic host_read_start();
    @(negedge clk); sel_n = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 oe after reset", {7'd0, bus_oe}, 8'h00);
    loc_read(1, 8'h0F, "R1 R10 control after reset");

    // mode off: host activity ignored
    host_write(8'h5A, 1'b1);
    loc_read(1, 8'h0F, "R7 flags with mode off");
    loc_read(0, 8'h00, "R7 no byte stored with mode off");
    host_read_start();
    chk("R7 oe with mode off", {7'd0, bus_oe}, 8'h00);
    @(negedge clk); sel_n = 1'b1; rd_n = 1'b1;

    loc_write(1, 8'h15);
    loc_read(1, 8'h15, "R10 control readback");
    loc_write(1, 8'hF5);
    loc_read(1, 8'h15, "R8 flag bits not writable");

    host_write(8'h77, 1'b0);
    loc_read(1, 8'h15, "R9 write without select");
    @(negedge clk); rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 read without select oe", {7'd0, bus_oe}, 8'h00);
    rd_n = 1'b1;

    host_write(8'hA5, 1'b1);
    loc_read(1, 8'h95, "R2 input-full set");
    loc_read(0, 8'hA5, "R2 byte stored");
    loc_read(1, 8'h15, "R4 input-full cleared");

    host_write(8'h11, 1'b1);
    host_write(8'h22, 1'b1);
    loc_read(1, 8'hB5, "R3 overrun set");
    loc_read(0, 8'h22, "R3 new byte overwrites");
    loc_read(1, 8'h35, "R4 clear keeps overrun");

    loc_write(1, 8'h35);
    loc_read(1, 8'h35, "R8 writing one keeps overrun");
    loc_write(1, 8'h15);
    loc_read(1, 8'h15, "R8 writing zero clears overrun");

    loc_write(0, 8'hC3);
    loc_read(1, 8'h55, "R5 output-full set");
    host_read_start();
    chk("R5 oe during read", {7'd0, bus_oe}, 8'h01);
    chk("R5 driven byte", bus_out, 8'hC3);
    rd_n = 1'b1;
    @(negedge clk);
    chk("R6 oe after read strobe rise", {7'd0, bus_oe}, 8'h00);
    @(negedge clk); sel_n = 1'b1;
    repeat (4) @(negedge clk);
    loc_read(1, 8'h15, "R5 output-full cleared by host read");

    loc_write(0, 8'h3C);
    host_read_start();
    chk("R5 second driven byte", bus_out, 8'h3C);
    sel_n = 1'b1;
    @(negedge clk);
    chk("R6 oe after select rise", {7'd0, bus_oe}, 8'h00);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    loc_read(1, 8'h15, "R5 output-full cleared after select rise");

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule